// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of unsigned integers on a grid of processing elements. Each element keeps its own running sum. Operands from the left matrix travel rightward along the grid rows, and operands from the right matrix travel downward along the grid columns. Every element adds the product of the pair it sees to its local sum on every clock. When the operands have drained through the grid, the element at grid position (i,j) holds entry (i,j) of the product.

To start a job, the user pulses `start` for one cycle. On each of the next N cycles the user presents one column of the left matrix and one row of the right matrix, without any skew. The block delays row i of the left stream by i cycles and column j of the right stream by j cycles. Outside that N-cycle window the edge inputs are ignored, and the grid sees zeros there. A registered `done` flag tells the user when all N*N sums are final. The sums stay readable in parallel on `c_out` until the next start.

Top module: `ostat_matmul`

## Requirements
- R1: After a synchronous reset, `done` is 0 and every field of `c_out` is 0.
- R2: The edge that samples `start`=1 clears all sums and `done`. In the following cycle every field of `c_out` is 0.
- R3: For k = 0..N-1, the user drives column k of the left matrix on `a_in` and row k of the right matrix on `b_in` in the k-th cycle after the start cycle. Once `done` is 1, each sum equals the unsigned dot product of row i of the left matrix with column j of the right matrix.
- R4: `done` stays 0 after the first 3N-2 rising edges that follow the start edge. It is 1 after the (3N-1)-th edge: for N=3, 0 after edge 7 and 1 after edge 8.
- R5: Edge input values sampled at the start edge, or sampled at any edge other than the N feed edges, have no effect on the sums. Once `done` is set, no operand is left travelling at the right or bottom edge of the grid.
- R6: While `done` is 1 and `start` is 0, `c_out` and `done` hold their values.
- R7: The sum width is 2W plus ceil(log2 N) bits. With every operand at its maximum (255 for W=8), every sum reads N*255*255 (195075 for N=3) with no wrap.
- R8: A `start` pulse in the middle of a job abandons that job. The new job's result is unaffected by the old job's operands.
- R9: The field layout is fixed. Sum (i,j) is `c_out[(i*N+j)*ACC_W +: ACC_W]`. Left-matrix entry (i,k) is on `a_in[i*W +: W]`. Right-matrix entry (k,j) is on `b_in[j*W +: W]`.
- R10: No sum ever decreases, except when it is cleared by a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that clears the sums and begins a job |
| a_in | input | N*W | One column of the left matrix, one W-bit field per grid row |
| b_in | input | N*W | One row of the right matrix, one W-bit field per grid column |
| done | output | 1 | Registered flag: all sums are final |
| c_out | output | N*N*ACC_W | All sums, row-major |

## Verification
The hardest case to reach from the ports is a start that arrives while operands are still in flight through the skew chains and the element registers. If any of that stale data survived, it would corrupt the next job without changing its timing. The stimulus feeds part of a job with random data and then restarts. In other runs it keeps random values on the edge inputs in every cycle outside the feed window, including the start cycle. The results are then checked against a reference product, and the sums are checked for stability after `done`.

// File: rtl/ostat_pkg.sv
package ostat_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

  // width that holds n full products of two opw-bit unsigned values
  function automatic int acc_width(input int opw, input int n);
    return 2 * opw + ((n > 1) ? $clog2(n) : 0);
  endfunction

endpackage

// File: rtl/ostat_seq.sv
module ostat_seq
  import ostat_pkg::*;
#(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic feed,
  output logic clr,
  output logic done
);

  localparam int LAST = 3 * N - 2;
  localparam int CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] LAST_C = CW'(LAST);
  localparam logic [CW-1:0] FEED_C = CW'(N);

  seq_state_e      state;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (start) begin
      state <= SEQ_RUN;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        SEQ_RUN: begin
          if (cnt == LAST_C) begin
            state <= SEQ_HOLD;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign feed = (state == SEQ_RUN) && (cnt < FEED_C);
  assign clr  = start;

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_RUN) |-> !done); // R4

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R6

  AST_FEED_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    done |-> !feed); // R5

endmodule

// File: rtl/ostat_skew.sv
module ostat_skew #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         feed,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);

  logic [W-1:0] stage [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst || clr) stage[0] <= '0;
          else            stage[0] <= feed ? d_in : '0;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst || clr) stage[s] <= '0;
          else            stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stage[DEPTH-1];

endmodule

// File: rtl/ostat_pe.sv
module ostat_pe #(
  parameter int W     = 8,
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [W-1:0]     m_in,
  input  logic [W-1:0]     n_in,
  output logic [W-1:0]     p_out,
  output logic [W-1:0]     q_out,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W-1:0] prod;

  assign prod = ACC_W'(m_in) * ACC_W'(n_in);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      p_out <= '0;
      q_out <= '0;
      acc   <= '0;
    end else begin
      p_out <= m_in;
      q_out <= n_in;
      acc   <= acc + prod;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !clr |=> acc >= $past(acc)); // R10

endmodule

// File: rtl/ostat_matmul.sv
module ostat_matmul
  import ostat_pkg::*;
#(
  parameter int N     = 3,
  parameter int W     = 8,
  parameter int ACC_W = acc_width(W, N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [N*W-1:0]       a_in,
  input  logic [N*W-1:0]       b_in,
  output logic                 done,
  output logic [N*N*ACC_W-1:0] c_out
);

  logic feed;
  logic clr;

  logic [W-1:0]     h_bus [N][N+1];
  logic [W-1:0]     v_bus [N+1][N];
  logic [ACC_W-1:0] sums  [N][N];
  logic [N*W-1:0]   right_edge;
  logic [N*W-1:0]   bottom_edge;

  ostat_seq #(.N(N)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .feed (feed),
    .clr  (clr),
    .done (done)
  );

  generate
    for (genvar r = 0; r < N; r++) begin : g_row_skew
      ostat_skew #(.W(W), .DEPTH(r + 1)) u_skew (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .feed (feed),
        .d_in (a_in[r*W +: W]),
        .q_out(h_bus[r][0])
      );
      assign right_edge[r*W +: W] = h_bus[r][N];
    end

    for (genvar c = 0; c < N; c++) begin : g_col_skew
      ostat_skew #(.W(W), .DEPTH(c + 1)) u_skew (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .feed (feed),
        .d_in (b_in[c*W +: W]),
        .q_out(v_bus[0][c])
      );
      assign bottom_edge[c*W +: W] = v_bus[N][c];
    end

    for (genvar r = 0; r < N; r++) begin : g_grid_row
      for (genvar c = 0; c < N; c++) begin : g_grid_col
        ostat_pe #(.W(W), .ACC_W(ACC_W)) u_pe (
          .clk  (clk),
          .rst  (rst),
          .clr  (clr),
          .m_in (h_bus[r][c]),
          .n_in (v_bus[r][c]),
          .p_out(h_bus[r][c+1]),
          .q_out(v_bus[r+1][c]),
          .acc  (sums[r][c])
        );
        assign c_out[(r*N+c)*ACC_W +: ACC_W] = sums[r][c];
      end
    end
  endgenerate

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (c_out == '0) && !done); // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(c_out)); // R6

  AST_EDGE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    done |=> (right_edge == '0) && (bottom_edge == '0)); // R5

endmodule

// File: tb/test_ostat_matmul.sv
module test_ostat_matmul;

  localparam int N     = 3;
  localparam int W     = 8;
  localparam int ACC_W = 2 * W + $clog2(N);

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 start;
  logic [N*W-1:0]       a_in;
  logic [N*W-1:0]       b_in;
  logic                 done;
  logic [N*N*ACC_W-1:0] c_out;

  int total = 0;
  int bad   = 0;

  int ma [N][N];
  int mb [N][N];

  always #5 clk = ~clk;

  ostat_matmul #(.N(N), .W(W), .ACC_W(ACC_W)) i_ostat_matmul (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .a_in (a_in),
    .b_in (b_in),
    .done (done),
    .c_out(c_out)
  );

  function automatic int expect_at(input int r, input int c);
    int s = 0;
    for (int k = 0; k < N; k++) s += ma[r][k] * mb[k][c];
    return s;
  endfunction

  function automatic int sum_at(input int r, input int c);
    return int'(c_out[(r*N+c)*ACC_W +: ACC_W]);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic noise(input bit noisy);
    a_in = noisy ? N*W'($urandom) : '0;
    b_in = noisy ? N*W'($urandom) : '0;
  endtask

  task automatic drive_step(input int k);
    for (int i = 0; i < N; i++) a_in[i*W +: W] = W'(ma[i][k]);
    for (int j = 0; j < N; j++) b_in[j*W +: W] = W'(mb[k][j]);
  endtask

  // full job: start pulse, feed, timing and result checks
  task automatic run_mm(input bit noisy);
    int snap [N][N];
    bit all_zero;
    @(negedge clk);
    start = 1'b1;
    noise(noisy);
    @(negedge clk);            // after the start edge
    start = 1'b0;
    all_zero = (c_out == '0);
    chk(all_zero && !done, "R2 clear after start", longint'(c_out[ACC_W-1:0]), 0);
    for (int k = 0; k < N; k++) begin
      drive_step(k);
      @(negedge clk);
    end
    noise(noisy);              // after edge N
    repeat (3 * N - 2 - N) @(negedge clk);
    chk(done == 1'b0, "R4 done low after edge 3N-2", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R4 done high after edge 3N-1", done, 1);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        chk(sum_at(r, c) == expect_at(r, c), "R3 R9 product entry", sum_at(r, c), expect_at(r, c));
        snap[r][c] = sum_at(r, c);
      end
    for (int t = 0; t < 4; t++) begin
      noise(1'b1);
      @(negedge clk);
    end
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        chk(sum_at(r, c) == snap[r][c], "R6 R5 hold after done", sum_at(r, c), snap[r][c]);
    chk(done == 1'b1, "R6 done held", done, 1);
    noise(1'b0);
  endtask

  task automatic rand_mats();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = int'($urandom_range(0, 255));
        mb[i][j] = int'($urandom_range(0, 255));
      end
  endtask

  initial begin
    #(200_000 * 10);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst   = 1'b1;
    start = 1'b0;
    a_in  = '0;
    b_in  = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(c_out == '0, "R1 sums after reset", longint'(c_out[ACC_W-1:0]), 0);

    // identity times B, quiet edges
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i == j) ? 1 : 0;
        mb[i][j] = i * N + j + 1;
      end
    run_mm(1'b0);

    // all operands at maximum: R7
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = 255;
        mb[i][j] = 255;
      end
    run_mm(1'b1);
    chk(sum_at(N-1, N-1) == 195075, "R7 full-scale sum", sum_at(N-1, N-1), 195075);

    // zero matrices with noisy edges: R5
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = 0;
        mb[i][j] = 0;
      end
    run_mm(1'b1);

    // restart mid-job: R8
    rand_mats();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drive_step(0);
    @(negedge clk);
    drive_step(1);
    rand_mats();
    run_mm(1'b1);

    // random jobs
    for (int n = 0; n < 20; n++) begin
      rand_mats();
      run_mm(n[0]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule